// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block sits on the controller side of a two-wire serial bus and brings a target back to a known idle state after a transfer was cut short, after power was lost, or after a system reset. A target left mid-byte may still be holding the data line low. On a recovery request the sequencer clocks the bus until the target lets go of the data line, generates a start condition, then a stop condition, and reports the outcome.

Both lines are driven as open-drain pull-down enables. The level actually present on each line is read back through sense inputs. A target that stretches the clock lengthens the high phase. The data line is judged released only when it is sensed high. The clock half-period is programmable in system clocks and is captured when a request is accepted.

Top module: `brec_bus_recover`

## Requirements
- R1: After reset both pull-down enables are 0, and the done and fail flags are 0.
- R2: A request accepted while idle pulls the clock line low on the next cycle. Every low phase lasts P system clocks, where P is the half-period input captured at that request.
- R3: A high phase releases the clock line. It ends only after P system clocks during which the clock line is sensed high, so clock stretching by a target lengthens it.
- R4: The data line is sampled at the end of each high phase. The first time it is sensed high, clocking stops, so the number of clock pulses equals the index of that high phase.
- R5: Once the data line is sensed high, the block pulls the data line low for P cycles while leaving the clock line released, which forms a start condition.
- R6: After the start, the data line is released with the clock line still released, which forms a stop condition. The stop is held for P cycles. Then done is pulsed high for exactly one cycle, with both lines released.
- R7: No more than 9 clock pulses are generated. If the data line is still low at the end of the ninth high phase, fail is pulsed for one cycle, both lines are released, and no start is generated.
- R8: A request that arrives while a sequence is running has no effect. The running sequence keeps its pulse count and its half-period, and no new sequence follows it.
- R9: A half-period input below 4 is treated as 4.
- R10: The data line is never pulled low while the block is pulling the clock line low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| recover_req | input | 1 | Start a recovery sequence (acted on only when idle) |
| half_period | input | DIV_W | Clock phase length in system clocks, minimum 4 |
| scl_sense | input | 1 | Sensed level of the clock line |
| sda_sense | input | 1 | Sensed level of the data line |
| scl_drive_low | output | 1 | Pull-down enable for the clock line |
| sda_drive_low | output | 1 | Pull-down enable for the data line |
| done | output | 1 | One-cycle pulse: recovery finished with start and stop |
| fail | output | 1 | One-cycle pulse: data line still low after 9 pulses |

## Verification
A wrong phase state shows up on the pull-down enables within one half-period. It appears as a low or high phase of the wrong length, or as a data pull-down while the clock is held low. A miscounted pulse total shows up at the end of the sequence, either as a premature or late done or fail, or as a start that is missing or was not asked for. The bench models a target that releases the data line after a chosen number of clock rises and can stretch each high phase. It compares the observed pulse count, phase lengths and start/stop edges against queued expectations when each sequence ends.

// File: rtl/brec_pkg.sv
package brec_pkg;

    localparam int MIN_HALF = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_START,
        ST_STOP
    } brec_state_e;

    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } line_drive_t;

    function automatic line_drive_t lines_for(brec_state_e s);
        line_drive_t d;
        d.scl_low = (s == ST_LOW);
        d.sda_low = (s == ST_START);
        return d;
    endfunction

endpackage

// File: rtl/brec_phase_timer.sv
module brec_phase_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (run && cnt_q != '0)
            cnt_q <= cnt_q - W'(1);
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/brec_pulse_counter.sv
module brec_pulse_counter #(
    parameter int MAX_PULSES = 9
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic inc,
    output logic at_last
);
    localparam int CW = $clog2(MAX_PULSES + 1);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt_q <= '0;
        else if (inc)
            cnt_q <= cnt_q + CW'(1);
    end

    assign at_last = (cnt_q == CW'(MAX_PULSES - 1));
endmodule

// File: rtl/brec_bus_recover.sv
module brec_bus_recover
    import brec_pkg::*;
#(
    parameter int DIV_W      = 16,
    parameter int MAX_CLOCKS = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             recover_req,
    input  logic [DIV_W-1:0] half_period,
    input  logic             scl_sense,
    input  logic             sda_sense,
    output logic             scl_drive_low,
    output logic             sda_drive_low,
    output logic             done,
    output logic             fail
);
    localparam logic [DIV_W-1:0] MIN_P = DIV_W'(MIN_HALF);

    brec_state_e      state_q, state_d;
    logic [DIV_W-1:0] period_m1_q;
    logic [DIV_W-1:0] req_period_m1;
    logic [DIV_W-1:0] load_val;
    logic             tmr_load, tmr_run, tmr_expired;
    logic             cnt_clr, cnt_inc, at_last;
    logic             done_d, fail_d;
    logic             busy;
    line_drive_t      drv;

    // clamp the requested half-period, then convert to a terminal count
    assign req_period_m1 = ((half_period < MIN_P) ? MIN_P : half_period) - DIV_W'(1);
    assign load_val      = (state_q == ST_IDLE) ? req_period_m1 : period_m1_q;
    assign busy          = (state_q != ST_IDLE);

    brec_phase_timer #(.W(DIV_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (load_val),
        .run      (tmr_run),
        .expired  (tmr_expired)
    );

    brec_pulse_counter #(.MAX_PULSES(MAX_CLOCKS)) u_pulses (
        .clk     (clk),
        .rst     (rst),
        .clear   (cnt_clr),
        .inc     (cnt_inc),
        .at_last (at_last)
    );

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_run  = 1'b0;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        done_d   = 1'b0;
        fail_d   = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (recover_req) begin
                    state_d  = ST_LOW;
                    tmr_load = 1'b1;
                    cnt_clr  = 1'b1;
                end
            end
            ST_LOW: begin
                tmr_run = 1'b1;
                if (tmr_expired) begin
                    state_d  = ST_HIGH;
                    tmr_load = 1'b1;
                end
            end
            ST_HIGH: begin
                // a stretched clock line holds the phase timer
                tmr_run = scl_sense;
                if (scl_sense && tmr_expired) begin
                    if (sda_sense) begin
                        state_d  = ST_START;
                        tmr_load = 1'b1;
                    end else if (at_last) begin
                        state_d = ST_IDLE;
                        fail_d  = 1'b1;
                    end else begin
                        state_d  = ST_LOW;
                        tmr_load = 1'b1;
                        cnt_inc  = 1'b1;
                    end
                end
            end
            ST_START: begin
                tmr_run = 1'b1;
                if (tmr_expired) begin
                    state_d  = ST_STOP;
                    tmr_load = 1'b1;
                end
            end
            ST_STOP: begin
                tmr_run = 1'b1;
                if (tmr_expired) begin
                    state_d = ST_IDLE;
                    done_d  = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            period_m1_q <= MIN_P - DIV_W'(1);
            done        <= 1'b0;
            fail        <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && recover_req)
                period_m1_q <= req_period_m1;
            done <= done_d;
            fail <= fail_d;
        end
    end

    assign drv           = lines_for(state_q);
    assign scl_drive_low = drv.scl_low;
    assign sda_drive_low = drv.sda_low;
endmodule

// File: rtl/brec_bus_recover_chk.sv
module brec_bus_recover_chk #(
    parameter int MAX_CLOCKS = 9
) (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic recover_req,
    input logic scl_drive_low,
    input logic sda_drive_low,
    input logic done,
    input logic fail
);
    logic [31:0] pulses_q;
    logic        scl_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pulses_q   <= '0;
            scl_prev_q <= 1'b0;
        end else begin
            scl_prev_q <= scl_drive_low;
            if (!busy)
                pulses_q <= '0;
            else if (scl_drive_low && !scl_prev_q)
                pulses_q <= pulses_q + 32'd1;
        end
    end

    AST_REQ_PULLS_SCL: assert property (@(posedge clk) disable iff (rst)
        (!busy && recover_req) |=> scl_drive_low);                        // R2
    AST_NO_SDA_WITH_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !(sda_drive_low && scl_drive_low));                               // R10
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                                  // R6
    AST_DONE_LINES_FREE: assert property (@(posedge clk) disable iff (rst)
        done |-> (!scl_drive_low && !sda_drive_low && !fail));            // R6
    AST_FAIL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        fail |=> !fail);                                                  // R7
    AST_PULSE_CAP: assert property (@(posedge clk) disable iff (rst)
        pulses_q <= 32'(MAX_CLOCKS));                                     // R7
endmodule

bind brec_bus_recover brec_bus_recover_chk #(.MAX_CLOCKS(MAX_CLOCKS)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .busy          (busy),
    .recover_req   (recover_req),
    .scl_drive_low (scl_drive_low),
    .sda_drive_low (sda_drive_low),
    .done          (done),
    .fail          (fail)
);

// File: tb/tb_brec_bus_recover.sv
`timescale 1ns/1ps
module tb_brec_bus_recover;
    localparam int DIV_W = 16;

    typedef struct {
        int clocks;
        bit ok;
        int period;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             recover_req = 1'b0;
    logic [DIV_W-1:0] half_period = '0;
    logic             scl_sense, sda_sense;
    logic             scl_drive_low, sda_drive_low, done, fail;

    bit stretch_hold = 1'b0;
    bit target_hold  = 1'b0;
    int release_after = 0;
    int rises = 0;
    int stretch_cycles = 0;
    int stretch_left = 0;

    int total = 0;
    int bad = 0;
    int seq_ends = 0;
    exp_t exp_q[$];

    assign scl_sense = !(scl_drive_low || stretch_hold);
    assign sda_sense = !(sda_drive_low || target_hold);

    always #4 clk = ~clk;

    brec_bus_recover #(.DIV_W(DIV_W), .MAX_CLOCKS(9)) dut (
        .clk           (clk),
        .rst           (rst),
        .recover_req   (recover_req),
        .half_period   (half_period),
        .scl_sense     (scl_sense),
        .sda_sense     (sda_sense),
        .scl_drive_low (scl_drive_low),
        .sda_drive_low (sda_drive_low),
        .done          (done),
        .fail          (fail)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // monitor: tracks phases at the falling edge and scores each sequence end
    bit prev_scl_drv = 0, prev_sda_drv = 0, prev_scl_now = 1, prev_done = 0, prev_fail = 0;
    bit in_low = 0, in_high = 0, in_start = 0, in_stop = 0;
    bit start_seen = 0, stop_seen = 0;
    int low_len = 0, high_len = 0, start_len = 0, stop_len = 0, clocks_seen = 0;

    always @(negedge clk) begin
        if (!rst) begin
            int p;
            bit scl_now, sda_now;
            exp_t e;
            p = (exp_q.size() > 0) ? exp_q[0].period : 4;

            if (prev_scl_drv && !scl_drive_low) stretch_left = stretch_cycles;
            else if (stretch_left > 0) stretch_left--;
            stretch_hold = (stretch_left > 0);
            scl_now = !scl_drive_low && !stretch_hold;
            if (scl_now && !prev_scl_now) rises++;
            target_hold = (rises < release_after);
            sda_now = !sda_drive_low && !target_hold;

            if (in_low) low_len++;
            if (in_high) high_len++;
            if (in_start) start_len++;
            if (in_stop) stop_len++;

            if (scl_drive_low && !prev_scl_drv) begin
                if (in_high) chk(high_len == p, "R3", "high phase length", high_len, p);
                in_high = 0; in_low = 1; low_len = 0; clocks_seen++;
            end
            if (!scl_drive_low && prev_scl_drv) begin
                chk(low_len == p, "R2", "low phase length", low_len, p);
                in_low = 0;
            end
            if (scl_now && !prev_scl_now && !in_low) begin
                in_high = 1; high_len = 0;
            end
            if (sda_drive_low && !prev_sda_drv) begin
                start_seen = scl_now; in_high = 0; in_start = 1; start_len = 0;
            end
            if (!sda_drive_low && prev_sda_drv) begin
                chk(start_len == p, "R5", "start hold length", start_len, p);
                stop_seen = scl_now && sda_now; in_start = 0; in_stop = 1; stop_len = 0;
            end
            if (done && prev_done) chk(0, "R6", "done wider than one cycle", 2, 1);
            if (fail && prev_fail) chk(0, "R7", "fail wider than one cycle", 2, 1);

            if ((done && !prev_done) || (fail && !prev_fail)) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R8", "unexpected sequence end", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    if (done) begin
                        chk(e.ok, "R6", "done outcome", 1, int'(e.ok));
                        chk(clocks_seen == e.clocks, "R4", "clock pulses", clocks_seen, e.clocks);
                        chk(start_seen, "R5", "start seen", int'(start_seen), 1);
                        chk(stop_seen, "R6", "stop seen", int'(stop_seen), 1);
                        chk(stop_len == p, "R6", "stop hold length", stop_len, p);
                    end else begin
                        chk(!e.ok, "R7", "fail outcome", 1, int'(!e.ok));
                        chk(clocks_seen == 9, "R7", "pulses before fail", clocks_seen, 9);
                        chk(!start_seen, "R7", "no start on fail", int'(start_seen), 0);
                    end
                    chk(!scl_drive_low && !sda_drive_low, "R6", "lines released at end",
                        int'(scl_drive_low) + int'(sda_drive_low), 0);
                end
                clocks_seen = 0; start_seen = 0; stop_seen = 0;
                in_low = 0; in_high = 0; in_start = 0; in_stop = 0;
                seq_ends++;
            end

            prev_scl_drv = scl_drive_low;
            prev_sda_drv = sda_drive_low;
            prev_scl_now = scl_now;
            prev_done    = done;
            prev_fail    = fail;
        end
    end

    // driver: queues the expected outcome, then issues the request
    task automatic run_case(input int hp, input int n, input int s, input bit extra);
        exp_t e;
        int start_ends;
        int guard;
        e.period = (hp < 4) ? 4 : hp;
        e.ok     = (n <= 9);
        e.clocks = (n == 0) ? 1 : ((n > 9) ? 9 : n);
        @(posedge clk);
        release_after  = n;
        rises          = 0;
        stretch_cycles = s;
        exp_q.push_back(e);
        start_ends = seq_ends;
        repeat (2) @(negedge clk);
        #1;
        half_period = DIV_W'(hp);
        recover_req = 1'b1;
        @(negedge clk);
        #1;
        recover_req = 1'b0;
        if (extra) begin
            // R8: a second request, with a different half-period, mid-sequence
            repeat (15) @(negedge clk);
            #1;
            half_period = DIV_W'(3);
            recover_req = 1'b1;
            @(negedge clk);
            #1;
            recover_req = 1'b0;
        end
        guard = 0;
        while (seq_ends == start_ends && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        chk(seq_ends != start_ends, "R4", "sequence ended", seq_ends - start_ends, 1);
        repeat (4 * e.period) @(negedge clk);
        chk(!scl_drive_low && !sda_drive_low, "R8", "bus stays idle after end",
            int'(scl_drive_low) + int'(sda_drive_low), 0);
    endtask

    initial begin : watchdog
        int cyc;
        cyc = 0;
        while (cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d expected=<%0d cycles", cyc, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        chk(!scl_drive_low && !sda_drive_low && !done && !fail, "R1", "reset outputs",
            int'(scl_drive_low) + int'(sda_drive_low) + int'(done) + int'(fail), 0);
        run_case(6, 3, 0, 0);   // R4 plain case
        run_case(2, 1, 0, 0);   // R9 clamp to 4
        run_case(5, 9, 0, 0);   // R7 success on the ninth pulse
        run_case(4, 10, 0, 0);  // R7 fail after nine pulses
        run_case(7, 4, 3, 0);   // R3 stretched high phases
        run_case(4, 2, 0, 1);   // R8 ignored mid-run request
        run_case(0, 0, 0, 0);   // R9 zero half-period, R10 start after one pulse
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule